// File: doc/BRIEF.md
# Trap Level Stack

This block keeps the nested trap context of a processor. When a trap is taken, it records the interrupted context in a slot chosen by the current trap level. The context is the current and next program counters, the trap type, and one 64-bit state word. That word packs the condition codes, the address-space identifier, the 12-bit processor state and the window pointer. The block then forms a vector from the trap base value and returns the new program counters, the forced processor state and the updated trap base. When the handler finishes with a return-and-skip or a return-and-reissue request, the block pops the most recent slot and returns the restored context.

The block updates its outputs one clock after an accepted request and pulses `upd_o` in that cycle. A trap taken in the last regular level raises the red-state bit. A trap taken at the maximum level stops the machine in an error state, which only reset clears.

Top module: `trap_level_stack`

## Requirements
- R1: After reset, `tl_o` is 0, `err_o` is 0, `upd_o` is 0 and every context output is 0.
- R2: An accepted trap stores `cur_pc`, `cur_npc`, `trap_type` and the state word in slot `tl_o`. The state word is `{24'b0, ccr, asi, 4'b0, pstate, cwp}`, which puts the condition codes at [39:32], the ASI at [31:24], the processor state at [19:8] and the window pointer at [7:0]. On trap entry, `ccr_o`, `asi_o` and `cwp_o` take the current values.
- R3: On trap entry, `pstate_o` becomes 12'h015. This sets alternate globals (bit 0), privileged (bit 2) and FP enable (bit 4). Bit 5 (red state) is also set when entry happens at level MAXTL-1.
- R4: On trap entry, `tbr_o` keeps `tbr_in` above bit 14. Bits [13:5] take `trap_type`, bits [4:0] are 0, and bit 14 is 1 only when `tl_o` was greater than 1 before entry.
- R5: After trap entry, `pc_o` equals `tbr_o` and `npc_o` equals `pc_o`+4.
- R6: Trap entry raises `tl_o` by one. Entry at MAXTL-1 moves the level to MAXTL.
- R7: A trap requested while `tl_o` equals MAXTL sets `err_o` and gives no update. `err_o` stays set until reset, and all later requests are ignored.
- R8: A return-and-skip (`done_req`) with `tl_o`>0 lowers `tl_o` by one. It sets `pc_o` to the saved next PC and `npc_o` to the saved next PC+4, and it restores ccr, asi, pstate and cwp from the saved word.
- R9: A return-and-reissue (`retry_req`) with `tl_o`>0 lowers `tl_o` by one. It sets `pc_o` to the saved PC and `npc_o` to the saved next PC, and it restores the packed fields.
- R10: A return request while `tl_o` is 0 changes no output and gives no `upd_o`.
- R11: A trap request wins over a return request in the same cycle, and `done_req` wins over `retry_req`.
- R12: `upd_o` is 1 exactly in the cycle after an accepted trap or return. `tt_o` shows the trap type saved at level `tl_o`-1, or 0 when `tl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | 9 | Type of the requested trap |
| done_req | input | 1 | Return past the trapping instruction |
| retry_req | input | 1 | Return and reissue the trapping instruction |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor state |
| cur_cwp | input | 8 | Current window pointer |
| cur_pc | input | PCW | Current program counter |
| cur_npc | input | PCW | Current next program counter |
| tbr_in | input | PCW | Current trap base value |
| upd_o | output | 1 | Outputs carry a new context this cycle |
| pc_o | output | PCW | New program counter |
| npc_o | output | PCW | New next program counter |
| tbr_o | output | PCW | Updated trap base value |
| ccr_o | output | 8 | New condition codes |
| asi_o | output | 8 | New address-space identifier |
| pstate_o | output | 12 | New processor state |
| cwp_o | output | 8 | New window pointer |
| tt_o | output | 9 | Trap type saved at the top level |
| tl_o | output | $clog2(MAXTL+1) | Current trap level |
| err_o | output | 1 | Error state, held until reset |

## Verification
The bench builds the block with MAXTL=3 and PCW=32. A maximum of three levels means a few traps reach the red-state level, the saturated level and the error state. Each boundary is hit several times in one short run. Between those visits, each level's slot is overwritten with fresh random context. A 32-bit counter width also puts real data above bit 14 of the trap base, so the bench can confirm that the replacement of the low bits leaves the upper part untouched.

// File: rtl/trap_level_stack.sv
module trap_level_stack #(
  parameter int MAXTL = 5,
  parameter int PCW = 64,
  localparam int TLW = $clog2(MAXTL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trap_req,
  input  logic [8:0]     trap_type,
  input  logic           done_req,
  input  logic           retry_req,
  input  logic [7:0]     cur_ccr,
  input  logic [7:0]     cur_asi,
  input  logic [11:0]    cur_pstate,
  input  logic [7:0]     cur_cwp,
  input  logic [PCW-1:0] cur_pc,
  input  logic [PCW-1:0] cur_npc,
  input  logic [PCW-1:0] tbr_in,
  output logic           upd_o,
  output logic [PCW-1:0] pc_o,
  output logic [PCW-1:0] npc_o,
  output logic [PCW-1:0] tbr_o,
  output logic [7:0]     ccr_o,
  output logic [7:0]     asi_o,
  output logic [11:0]    pstate_o,
  output logic [7:0]     cwp_o,
  output logic [8:0]     tt_o,
  output logic [TLW-1:0] tl_o,
  output logic           err_o
);
  localparam logic [TLW-1:0] TL_MAX  = TLW'(MAXTL);
  localparam logic [TLW-1:0] TL_LAST = TLW'(MAXTL - 1);
  localparam logic [11:0]    PS_TRAP = 12'h015;
  localparam logic [11:0]    PS_RED  = 12'h020;
  localparam logic [PCW-1:0] FOUR    = PCW'(4);

  logic [63:0]    st_mem  [MAXTL];
  logic [PCW-1:0] pc_mem  [MAXTL];
  logic [PCW-1:0] npc_mem [MAXTL];
  logic [8:0]     tt_mem  [MAXTL];

  wire            take_trap = trap_req && !err_o && (tl_o != TL_MAX);
  wire            hit_max   = trap_req && !err_o && (tl_o == TL_MAX);
  wire            take_ret  = !trap_req && !err_o && (tl_o != '0) && (done_req || retry_req);
  wire [TLW-1:0]  top       = tl_o - 1'b1;
  wire [63:0]     packed_w  = {24'b0, cur_ccr, cur_asi, 4'b0, cur_pstate, cur_cwp};
  wire [PCW-1:0]  vec       = {tbr_in[PCW-1:15], tl_o > TLW'(1), trap_type, 5'b0};
  wire [63:0]     saved     = st_mem[top];

  assign tt_o = (tl_o == '0) ? 9'd0 : tt_mem[top];

  always_ff @(posedge clk) begin
    if (take_trap) begin
      st_mem[tl_o]  <= packed_w;
      pc_mem[tl_o]  <= cur_pc;
      npc_mem[tl_o] <= cur_npc;
      tt_mem[tl_o]  <= trap_type;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_o    <= 1'b0;
      pc_o     <= '0;
      npc_o    <= '0;
      tbr_o    <= '0;
      ccr_o    <= '0;
      asi_o    <= '0;
      pstate_o <= '0;
      cwp_o    <= '0;
      tl_o     <= '0;
      err_o    <= 1'b0;
    end else begin
      upd_o <= take_trap || take_ret;
      if (hit_max) err_o <= 1'b1;
      if (take_trap) begin
        tbr_o    <= vec;
        pc_o     <= vec;
        npc_o    <= vec + FOUR;
        ccr_o    <= cur_ccr;
        asi_o    <= cur_asi;
        cwp_o    <= cur_cwp;
        pstate_o <= (tl_o == TL_LAST) ? (PS_TRAP | PS_RED) : PS_TRAP;
        tl_o     <= tl_o + 1'b1;
      end else if (take_ret) begin
        pc_o     <= done_req ? npc_mem[top] : pc_mem[top];
        npc_o    <= done_req ? npc_mem[top] + FOUR : npc_mem[top];
        ccr_o    <= saved[39:32];
        asi_o    <= saved[31:24];
        pstate_o <= saved[19:8];
        cwp_o    <= saved[7:0];
        tl_o     <= top;
      end
    end
  end
endmodule

module trap_level_stack_chk #(
  parameter int MAXTL = 5,
  parameter int PCW = 64,
  localparam int TLW = $clog2(MAXTL + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trap_req,
  input logic           done_req,
  input logic           retry_req,
  input logic           upd_o,
  input logic [PCW-1:0] pc_o,
  input logic [PCW-1:0] npc_o,
  input logic [PCW-1:0] tbr_o,
  input logic [11:0]    pstate_o,
  input logic [TLW-1:0] tl_o,
  input logic           err_o
);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> err_o);
  // R7
  max_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !err_o && tl_o == TLW'(MAXTL) |=> err_o && !upd_o);
  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tl_o <= TLW'(MAXTL));
  // R5
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !err_o && tl_o < TLW'(MAXTL) |=> upd_o && pc_o == tbr_o && npc_o == pc_o + PCW'(4));
  // R3
  red_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !err_o && tl_o == TLW'(MAXTL - 1) |=> pstate_o[5] && pstate_o[4] && pstate_o[2] && pstate_o[0]);
  // R10
  empty_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req && (done_req || retry_req) && tl_o == '0 |=> !upd_o && $stable(tl_o) && $stable(pc_o));
  // R12
  error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> !upd_o);
endmodule

bind trap_level_stack trap_level_stack_chk #(.MAXTL(MAXTL), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .done_req(done_req), .retry_req(retry_req),
  .upd_o(upd_o), .pc_o(pc_o), .npc_o(npc_o), .tbr_o(tbr_o), .pstate_o(pstate_o),
  .tl_o(tl_o), .err_o(err_o));

// File: tb/test_trap_level_stack.sv
module test_trap_level_stack;
  localparam int MAXTL = 3;
  localparam int PCW = 32;
  localparam int TLW = $clog2(MAXTL + 1);

  logic clk = 0, rst_n = 0;
  logic trap_req = 0, done_req = 0, retry_req = 0;
  logic [8:0] trap_type = 0;
  logic [7:0] cur_ccr = 0, cur_asi = 0, cur_cwp = 0;
  logic [11:0] cur_pstate = 0;
  logic [PCW-1:0] cur_pc = 0, cur_npc = 0, tbr_in = 0;
  logic upd_o, err_o;
  logic [PCW-1:0] pc_o, npc_o, tbr_o;
  logic [7:0] ccr_o, asi_o, cwp_o;
  logic [11:0] pstate_o;
  logic [8:0] tt_o;
  logic [TLW-1:0] tl_o;

  trap_level_stack #(.MAXTL(MAXTL), .PCW(PCW)) i_trap_level_stack (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  string tag = "R1";

  int m_tl; bit m_err, m_upd;
  logic [PCW-1:0] m_pc, m_npc, m_tbr;
  logic [7:0] m_ccr, m_asi, m_cwp;
  logic [11:0] m_ps;
  logic [63:0] s_w[MAXTL];
  logic [PCW-1:0] s_pc[MAXTL], s_npc[MAXTL];
  logic [8:0] s_tt[MAXTL];

  task automatic chk(input bit ok, input string r, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_tl = 0; m_err = 0; m_upd = 0; m_pc = 0; m_npc = 0; m_tbr = 0;
    m_ccr = 0; m_asi = 0; m_cwp = 0; m_ps = 0;
  endtask

  task automatic model_step();
    m_upd = 0;
    if (m_err) return;
    if (trap_req) begin
      if (m_tl == MAXTL) begin
        m_err = 1;
        return;
      end
      s_w[m_tl] = {24'b0, cur_ccr, cur_asi, 4'b0, cur_pstate, cur_cwp};
      s_pc[m_tl] = cur_pc; s_npc[m_tl] = cur_npc; s_tt[m_tl] = trap_type;
      m_tbr = (tbr_in & ~32'h7fff) | (trap_type << 5) | ((m_tl > 1) ? 32'h4000 : 0);
      m_pc = m_tbr; m_npc = m_tbr + 4;
      m_ccr = cur_ccr; m_asi = cur_asi; m_cwp = cur_cwp;
      m_ps = 12'h015 | ((m_tl == MAXTL - 1) ? 12'h020 : 12'h000);
      m_tl++; m_upd = 1;
    end else if ((done_req || retry_req) && m_tl > 0) begin
      m_tl--;
      if (done_req) begin m_pc = s_npc[m_tl]; m_npc = s_npc[m_tl] + 4; end
      else begin m_pc = s_pc[m_tl]; m_npc = s_npc[m_tl]; end
      m_ccr = s_w[m_tl][39:32]; m_asi = s_w[m_tl][31:24];
      m_ps = s_w[m_tl][19:8]; m_cwp = s_w[m_tl][7:0];
      m_upd = 1;
    end
  endtask

  task automatic compare();
    chk(tl_o == TLW'(m_tl), "R6", "tl", tl_o, m_tl);
    chk(err_o == m_err, "R7", "err", err_o, m_err);
    chk(upd_o == m_upd, "R12", "upd", upd_o, m_upd);
    chk(pc_o == m_pc, tag, "pc", pc_o, m_pc);
    chk(npc_o == m_npc, tag, "npc", npc_o, m_npc);
    chk(tbr_o == m_tbr, "R4", "tbr", tbr_o, m_tbr);
    chk(pstate_o == m_ps, "R3", "pstate", pstate_o, m_ps);
    chk({ccr_o, asi_o, cwp_o} == {m_ccr, m_asi, m_cwp}, "R2", "ccr/asi/cwp",
        {ccr_o, asi_o, cwp_o}, {m_ccr, m_asi, m_cwp});
    chk(tt_o == ((m_tl == 0) ? 9'd0 : s_tt[m_tl-1]), "R12", "tt", tt_o,
        (m_tl == 0) ? 9'd0 : s_tt[m_tl-1]);
  endtask

  task automatic step(input bit t, input bit d, input bit r, input logic [8:0] ty, input string tg);
    trap_req = t; done_req = d; retry_req = r; trap_type = ty; tag = tg;
    cur_ccr = 8'($urandom); cur_asi = 8'($urandom); cur_cwp = 8'($urandom);
    cur_pstate = 12'($urandom); cur_pc = $urandom; cur_npc = $urandom; tbr_in = $urandom;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    trap_req = 0; done_req = 0; retry_req = 0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1; tag = "R1";
    compare(); // R1 reset state
    for (int pass = 0; pass < 3; pass++) begin
      step(1, 0, 0, 9'h041, "R5");
      step(1, 0, 0, 9'h1ff, "R5");
      step(1, 0, 0, 9'h0a5, "R5");       // R6 saturation, R3 red bit
      step(0, 0, 1, 0, "R9");
      step(0, 1, 0, 0, "R8");
      step(0, 0, 0, 0, "R12");
      step(1, 0, 0, 9'h00c, "R5");
      step(0, 1, 1, 0, "R11");           // done wins over retry
      step(1, 1, 0, 9'h033, "R11");      // trap wins over done
      step(0, 0, 1, 0, "R9");
      step(0, 1, 0, 0, "R8");
      step(0, 1, 0, 0, "R10");           // empty stack return ignored
      step(0, 0, 1, 0, "R10");
    end
    step(1, 0, 0, 9'h011, "R5");
    step(1, 0, 0, 9'h022, "R5");
    step(1, 0, 0, 9'h033, "R5");
    step(1, 0, 0, 9'h044, "R7");         // trap at maximum level
    step(0, 1, 0, 0, "R7");
    step(1, 0, 0, 9'h055, "R7");
    step(0, 0, 1, 0, "R7");
    rst_n = 0; @(posedge clk); model_reset(); @(negedge clk); rst_n = 1;
    tag = "R1"; compare();
    step(1, 0, 0, 9'h077, "R5");
    step(0, 0, 1, 0, "R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule